// File: doc/BRIEF.md
# Block Transfer and Search Sequencer

This block runs the auto-stepping block operations of an 8-bit processor core: memory-to-memory copy, search of a memory range for the accumulator value, and block transfers between memory and an I/O port. A single `start_i` pulse loads a source pointer, a destination pointer, a 16-bit count, the accumulator and the incoming flag byte. It also latches the operation, the step direction and whether the operation repeats. The sequencer then drives a single-cycle memory port and a single-cycle I/O port until its termination rule is met.

Each iteration always takes three clock cycles: fetch, execute, update. A copy moves the byte at the source pointer to the destination pointer. A search subtracts the byte from the accumulator and keeps only the flags. An input step stores a byte read from the port into memory. An output step sends a memory byte to the port. For the I/O forms, the count register is split into two halves. The upper half is an 8-bit iteration count and the lower half is the port address, which the block never modifies. When the block finishes, it reports the updated registers and flags and pulses `done_o` for one cycle.

Top module: `blk_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `mem_we_o`, `io_we_o` and `io_rd_o` are all low.
- R2: In the idle state, `start_i` loads `src_i`, `dst_i`, `cnt_i`, `acc_i`, `flags_i`, `op_i`, `dec_i` and `rep_i`. While a run is in progress, `start_i` and all of these inputs are ignored.
- R3: When `op_i`=0 (copy), each iteration writes the byte at the source pointer to the destination pointer. Both pointers then step by +1, or by -1 when `dec_i`=1, and the 16-bit count decrements by one.
- R4: A repeating copy continues until the count reaches zero. A non-repeating copy performs exactly one iteration.
- R5: When `op_i`=1 (search), each iteration reads the byte at the source pointer and writes nothing. It then steps the source pointer and decrements the 16-bit count. The flag byte uses these bit positions: sign 7, zero 6, half-borrow 4, parity/overflow 2, subtract 1, carry 0. Sign takes bit 7 of acc minus byte, zero is set when the two are equal, half-borrow is set when acc[3:0] < byte[3:0], and subtract is set to 1.
- R6: A repeating search stops after the first iteration whose byte equals the accumulator, or whose count reaches zero, whichever comes first.
- R7: When `op_i`=2 (input), each iteration reads the port addressed by `cnt_i[7:0]` and writes the value to memory at the source pointer. It then steps the pointer and decrements `cnt[15:8]`. `cnt[7:0]` is never changed.
- R8: When `op_i`=3 (output), each iteration sends the byte at the source pointer to the port addressed by `cnt_i[7:0]`. It then steps the pointer and decrements `cnt[15:8]`. At most one of `mem_we_o`, `io_we_o` and `io_rd_o` is high in any cycle.
- R9: Repeating I/O forms continue until `cnt[15:8]` reaches zero. After each I/O iteration, subtract is set to 1 and zero reflects whether `cnt[15:8]` is now zero. All other flag bits are unchanged.
- R10: After each copy iteration, half-borrow and subtract are cleared and parity/overflow is set exactly when the count is nonzero. Sign, zero, carry, bit 5 and bit 3 are unchanged.
- R11: After each search iteration, parity/overflow is set exactly when the count is nonzero. Carry, bit 5 and bit 3 are unchanged.
- R12: Each iteration keeps `busy_o` high for exactly three cycles. `done_o` is high for exactly one cycle after the final update, with all register outputs already final.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation when idle |
| op_i | input | 2 | 0 copy, 1 search, 2 input, 3 output |
| dec_i | input | 1 | 1 steps pointers downward |
| rep_i | input | 1 | 1 repeats until termination |
| src_i | input | ADDR_W | Initial source pointer |
| dst_i | input | ADDR_W | Initial destination pointer |
| cnt_i | input | CNT_W | Initial count; for I/O: {iterations, port} |
| acc_i | input | 8 | Accumulator for search |
| flags_i | input | 8 | Incoming flag byte |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_rdata_i | input | 8 | Memory read data, valid in the same cycle |
| mem_we_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | 8 | Memory write data |
| io_addr_o | output | CNT_W/2 | Port address |
| io_rd_o | output | 1 | Port read strobe |
| io_rdata_i | input | 8 | Port read data, valid in the same cycle |
| io_we_o | output | 1 | Port write strobe |
| io_wdata_o | output | 8 | Port write data |
| src_o | output | ADDR_W | Current source pointer |
| dst_o | output | ADDR_W | Current destination pointer |
| cnt_o | output | CNT_W | Current count |
| flags_o | output | 8 | Current flag byte |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench sweeps every operation, both step directions and both run modes over short counts, and predicts each result with a software model. Searches place the matching byte at every position of the window and also outside it. A sequencer that tests termination before decrementing, or ignores the match, would stop one element late or run past the match, and would leave the wrong zero and parity/overflow flags. One copy runs its pointer across the top of the address space; a pointer that fails to wrap at that boundary would land on the wrong bytes. Other runs hold `start_i` high and change every input mid-run, so a design that reloads while busy or lets the port address decrement would diverge from the model.

// File: rtl/blk_seq_pkg.sv
package blk_seq_pkg;
  typedef enum logic [1:0] {OP_COPY = 2'd0, OP_CMP = 2'd1, OP_IN = 2'd2, OP_OUT = 2'd3} op_e;
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_EX, ST_UP} st_e;
  localparam int F_S  = 7;
  localparam int F_Z  = 6;
  localparam int F_H  = 4;
  localparam int F_PV = 2;
  localparam int F_N  = 1;
  localparam int F_C  = 0;
endpackage

// File: rtl/blk_seq_ctrl.sv
module blk_seq_ctrl
  import blk_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic rep_i,
  input  logic stop_i,
  output st_e  st_o,
  output logic load_o,
  output logic done_o
);
  st_e  st_q;
  logic rep_q, done_q;

  assign load_o = (st_q == ST_IDLE) && start_i;
  assign st_o   = st_q;
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      rep_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (start_i) begin
          st_q  <= ST_RD;
          rep_q <= rep_i;
        end
        ST_RD: st_q <= ST_EX;
        ST_EX: st_q <= ST_UP;
        default: begin
          if (rep_q && !stop_i) st_q <= ST_RD;
          else begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end
        end
      endcase
    end
  end

  assert_done_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  assert_rd_to_ex_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RD) |=> (st_q == ST_EX));
  assert_ex_to_up_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_EX) |=> (st_q == ST_UP));
  assert_busy_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE && st_q != ST_UP) |=> (st_q != ST_IDLE));
endmodule

// File: rtl/blk_seq_dp.sv
module blk_seq_dp
  import blk_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  localparam int IO_W  = CNT_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  st_e               st_i,
  input  logic              load_i,
  input  logic [1:0]        op_i,
  input  logic              dec_i,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [7:0]        acc_i,
  input  logic [7:0]        flags_i,
  input  logic [7:0]        mem_rdata_i,
  input  logic [7:0]        io_rdata_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [7:0]        mem_wdata_o,
  output logic [IO_W-1:0]   io_addr_o,
  output logic              io_rd_o,
  output logic              io_we_o,
  output logic [7:0]        io_wdata_o,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [7:0]        flags_o,
  output logic              stop_o
);
  localparam logic [ADDR_W-1:0] A_ONE = ADDR_W'(1);
  localparam logic [CNT_W-1:0]  C_ONE = CNT_W'(1);
  localparam logic [IO_W-1:0]   B_ONE = IO_W'(1);

  logic [ADDR_W-1:0] src_q, dst_q, src_nxt, dst_nxt;
  logic [CNT_W-1:0]  cnt_q, cnt_nxt, cnt_mem_nxt;
  logic [IO_W-1:0]   b_nxt;
  logic [7:0]        acc_q, data_q, flags_q, flags_nxt, diff;
  op_e               op_q;
  logic              dec_q, io_op, match;

  assign io_op       = (op_q == OP_IN) || (op_q == OP_OUT);
  assign src_nxt     = dec_q ? src_q - A_ONE : src_q + A_ONE;
  assign dst_nxt     = dec_q ? dst_q - A_ONE : dst_q + A_ONE;
  assign cnt_mem_nxt = cnt_q - C_ONE;
  assign b_nxt       = cnt_q[CNT_W-1:IO_W] - B_ONE;
  assign cnt_nxt     = io_op ? {b_nxt, cnt_q[IO_W-1:0]} : cnt_mem_nxt;
  assign diff        = acc_q - data_q;
  assign match       = (acc_q == data_q);
  assign stop_o      = io_op ? (b_nxt == '0)
                             : ((cnt_mem_nxt == '0) || ((op_q == OP_CMP) && match));

  always_comb begin
    flags_nxt = flags_q;
    case (op_q)
      OP_COPY: begin
        flags_nxt[F_H]  = 1'b0;
        flags_nxt[F_N]  = 1'b0;
        flags_nxt[F_PV] = (cnt_mem_nxt != '0);
      end
      OP_CMP: begin
        flags_nxt[F_S]  = diff[7];
        flags_nxt[F_Z]  = match;
        flags_nxt[F_H]  = (acc_q[3:0] < data_q[3:0]);
        flags_nxt[F_PV] = (cnt_mem_nxt != '0);
        flags_nxt[F_N]  = 1'b1;
      end
      default: begin
        flags_nxt[F_N] = 1'b1;
        flags_nxt[F_Z] = (b_nxt == '0);
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q   <= '0;
      dst_q   <= '0;
      cnt_q   <= '0;
      acc_q   <= '0;
      data_q  <= '0;
      flags_q <= '0;
      op_q    <= OP_COPY;
      dec_q   <= 1'b0;
    end else if (load_i) begin
      src_q   <= src_i;
      dst_q   <= dst_i;
      cnt_q   <= cnt_i;
      acc_q   <= acc_i;
      flags_q <= flags_i;
      op_q    <= op_e'(op_i);
      dec_q   <= dec_i;
    end else if (st_i == ST_RD) begin
      data_q <= (op_q == OP_IN) ? io_rdata_i : mem_rdata_i;
    end else if (st_i == ST_UP) begin
      src_q   <= src_nxt;
      if (op_q == OP_COPY) dst_q <= dst_nxt;
      cnt_q   <= cnt_nxt;
      flags_q <= flags_nxt;
    end
  end

  // copy writes at destination during execute; all else addresses the source
  assign mem_addr_o  = ((st_i == ST_EX) && (op_q == OP_COPY)) ? dst_q : src_q;
  assign mem_we_o    = (st_i == ST_EX) && ((op_q == OP_COPY) || (op_q == OP_IN));
  assign mem_wdata_o = data_q;
  assign io_addr_o   = cnt_q[IO_W-1:0];
  assign io_rd_o     = (st_i == ST_RD) && (op_q == OP_IN);
  assign io_we_o     = (st_i == ST_EX) && (op_q == OP_OUT);
  assign io_wdata_o  = data_q;
  assign src_o       = src_q;
  assign dst_o       = dst_q;
  assign cnt_o       = cnt_q;
  assign flags_o     = flags_q;

  assert_cnt_drop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_UP && !io_op) |=> (cnt_q + C_ONE == $past(cnt_q)));
  assert_carry_kept_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_UP) |=> (flags_q[F_C] == $past(flags_q[F_C])));
  assert_port_kept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_UP && io_op) |=> (cnt_q[IO_W-1:0] == $past(cnt_q[IO_W-1:0])));
  assert_search_no_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q == OP_CMP) |-> (!mem_we_o && !io_we_o));
  assert_strobe_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_we_o, io_we_o, io_rd_o}));
endmodule

// File: rtl/blk_seq.sv
module blk_seq
  import blk_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  localparam int IO_W  = CNT_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic              dec_i,
  input  logic              rep_i,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [7:0]        acc_i,
  input  logic [7:0]        flags_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [7:0]        mem_rdata_i,
  output logic              mem_we_o,
  output logic [7:0]        mem_wdata_o,
  output logic [IO_W-1:0]   io_addr_o,
  output logic              io_rd_o,
  input  logic [7:0]        io_rdata_i,
  output logic              io_we_o,
  output logic [7:0]        io_wdata_o,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [7:0]        flags_o,
  output logic              busy_o,
  output logic              done_o
);
  st_e  st;
  logic load, stop;

  blk_seq_ctrl u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .rep_i  (rep_i),
    .stop_i (stop),
    .st_o   (st),
    .load_o (load),
    .done_o (done_o)
  );

  blk_seq_dp #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .st_i       (st),
    .load_i     (load),
    .op_i       (op_i),
    .dec_i      (dec_i),
    .src_i      (src_i),
    .dst_i      (dst_i),
    .cnt_i      (cnt_i),
    .acc_i      (acc_i),
    .flags_i    (flags_i),
    .mem_rdata_i(mem_rdata_i),
    .io_rdata_i (io_rdata_i),
    .mem_addr_o (mem_addr_o),
    .mem_we_o   (mem_we_o),
    .mem_wdata_o(mem_wdata_o),
    .io_addr_o  (io_addr_o),
    .io_rd_o    (io_rd_o),
    .io_we_o    (io_we_o),
    .io_wdata_o (io_wdata_o),
    .src_o      (src_o),
    .dst_o      (dst_o),
    .cnt_o      (cnt_o),
    .flags_o    (flags_o),
    .stop_o     (stop)
  );

  assign busy_o = (st != ST_IDLE);

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_we_o && !io_we_o && !io_rd_o));
endmodule

// File: tb/tb_blk_seq.sv
module tb_blk_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        start_i = 0, dec_i = 0, rep_i = 0;
  logic [1:0]  op_i = 0;
  logic [15:0] src_i = 0, dst_i = 0, cnt_i = 0;
  logic [7:0]  acc_i = 0, flags_i = 0;
  logic [15:0] mem_addr, src_o, dst_o, cnt_o;
  logic [7:0]  mem_rdata, mem_wdata, io_addr, io_rdata, io_wdata, flags_o;
  logic        mem_we, io_rd, io_we, busy_o, done_o;

  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  logic [7:0] exp_out [16];
  logic [7:0] act_out [16];
  int n_chk = 0, n_fail = 0;

  assign mem_rdata = mem[mem_addr[7:0]];
  assign io_rdata  = src_o[7:0] ^ io_addr ^ 8'h96;

  blk_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .op_i(op_i), .dec_i(dec_i),
    .rep_i(rep_i), .src_i(src_i), .dst_i(dst_i), .cnt_i(cnt_i), .acc_i(acc_i),
    .flags_i(flags_i), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .mem_we_o(mem_we), .mem_wdata_o(mem_wdata), .io_addr_o(io_addr), .io_rd_o(io_rd),
    .io_rdata_i(io_rdata), .io_we_o(io_we), .io_wdata_o(io_wdata), .src_o(src_o),
    .dst_o(dst_o), .cnt_o(cnt_o), .flags_o(flags_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] stp(input logic [15:0] x, input logic d);
    return d ? x - 16'd1 : x + 16'd1;
  endfunction

  function automatic logic [7:0] patt(input int i, input logic [7:0] seed);
    return 8'(i * 7) + seed + 8'd3;
  endfunction

  task automatic run(input logic [1:0] op, input logic dec, input logic rep,
                     input logic [15:0] src, input logic [15:0] dst, input logic [15:0] cnt,
                     input logic [7:0] acc, input logic [7:0] fl, input logic noise,
                     input logic [7:0] seed);
    logic [15:0] p, q, c;
    logic [7:0]  f, b, d, v;
    logic        stop, got_done, port_bad;
    int it, cyc, n_exp, n_act, bad;
    string rp, rc, rf, rm;
    for (int i = 0; i < 256; i++) begin
      mem[i] = patt(i, seed);
      exp_mem[i] = mem[i];
    end
    p = src; q = dst; c = cnt; f = fl; it = 0; n_exp = 0;
    do begin
      case (op)
        2'd0: begin
          exp_mem[q[7:0]] = exp_mem[p[7:0]];
          p = stp(p, dec); q = stp(q, dec); c = c - 16'd1;
          f[4] = 1'b0; f[1] = 1'b0; f[2] = (c != 0); stop = (c == 0);
        end
        2'd1: begin
          b = exp_mem[p[7:0]]; d = acc - b;
          f[7] = d[7]; f[6] = (d == 0); f[4] = (acc[3:0] < b[3:0]); f[1] = 1'b1;
          p = stp(p, dec); c = c - 16'd1; f[2] = (c != 0);
          stop = (c == 0) || (d == 0);
        end
        default: begin
          if (op == 2'd2) begin
            v = p[7:0] ^ c[7:0] ^ 8'h96;
            exp_mem[p[7:0]] = v;
          end else begin
            if (n_exp < 16) exp_out[n_exp] = exp_mem[p[7:0]];
            n_exp++;
          end
          p = stp(p, dec); c[15:8] = c[15:8] - 8'd1;
          f[1] = 1'b1; f[6] = (c[15:8] == 0); stop = (c[15:8] == 0);
        end
      endcase
      it++;
    end while (rep && !stop);

    case (op)
      2'd0: begin rp = "R3"; rc = "R4"; rf = "R10"; rm = "R3"; end
      2'd1: begin rp = "R5"; rc = "R6"; rf = "R11"; rm = "R5"; end
      2'd2: begin rp = "R7"; rc = "R9"; rf = "R9";  rm = "R7"; end
      default: begin rp = "R8"; rc = "R9"; rf = "R9"; rm = "R8"; end
    endcase
    if (noise) begin rp = {"R2 ", rp}; rc = {"R2 ", rc}; end

    @(negedge clk);
    op_i = op; dec_i = dec; rep_i = rep; src_i = src; dst_i = dst; cnt_i = cnt;
    acc_i = acc; flags_i = fl; start_i = 1'b1;
    cyc = 0; n_act = 0; got_done = 0; port_bad = 0;
    for (int k = 0; k < 2000 && !got_done; k++) begin
      @(negedge clk);
      if (!noise) start_i = 1'b0;
      else begin
        src_i = ~src_i; dst_i = dst_i + 16'd3; cnt_i = cnt_i ^ 16'h5555;
        op_i = op_i + 2'd1; dec_i = ~dec_i; rep_i = ~rep_i;
        acc_i = acc_i + 8'd1; flags_i = ~flags_i;
      end
      if (busy_o) cyc++;
      if (mem_we) mem[mem_addr[7:0]] = mem_wdata;
      if (io_we) begin
        if (n_act < 16) act_out[n_act] = io_wdata;
        n_act++;
        if (io_addr != cnt[7:0]) port_bad = 1;
      end
      if (io_rd && io_addr != cnt[7:0]) port_bad = 1;
      if (done_o) begin got_done = 1; start_i = 1'b0; end
    end
    chk({"R12 done seen ", rp}, 32'(got_done), 32'd1);
    chk({rp, " src pointer"}, 32'(src_o), 32'(p));
    chk({rp, " dst pointer"}, 32'(dst_o), 32'(q));
    chk({rc, " count"}, 32'(cnt_o), 32'(c));
    chk({rf, " flags"}, 32'(flags_o), 32'(f));
    chk({"R12 busy cycles ", rp}, 32'(cyc), 32'(3 * it));
    bad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) bad++;
    chk({rm, " memory mismatches"}, 32'(bad), 32'd0);
    chk({"R8 port address ", rp}, 32'(port_bad), 32'd0);
    chk({"R8 output count ", rp}, 32'(n_act), 32'(n_exp));
    for (int i = 0; i < n_exp && i < 16; i++)
      chk({"R8 output byte ", rp}, 32'(act_out[i]), 32'(exp_out[i]));
    @(negedge clk);
    chk({"R12 done one cycle ", rp}, 32'(done_o), 32'd0);
    chk({"R12 idle after run ", rp}, 32'(busy_o), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", 32'(busy_o), 32'd0);
    chk("R1 done in reset", 32'(done_o), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 strobes after reset", {29'd0, mem_we, io_we, io_rd}, 32'd0);
    chk("R1 done after reset", 32'(done_o), 32'd0);

    // sweep: operation x direction x mode x count
    for (int op = 0; op < 4; op++)
      for (int dc = 0; dc < 2; dc++)
        for (int rp = 0; rp < 2; rp++)
          for (int n = 1; n <= 4; n++) begin
            logic [15:0] s, t, cn;
            logic [7:0] a, sd;
            sd = 8'(n * 11 + op * 5 + dc);
            s  = dc ? 16'h006F : 16'h0020;
            t  = dc ? 16'h00DF : 16'h0090;
            cn = (op < 2) ? 16'(n) : {8'(n), 8'h3C + 8'(op)};
            a  = (n % 2 == 0) ? patt(dc ? s - (n - 2) : s + (n - 2), sd)
                              : patt(s + 100, sd);
            run(2'(op), dc[0], rp[0], s, t, cn, a, 8'h5A ^ 8'(n * 29 + op), 1'b0, sd);
          end

    // search: match at each window position, and no match (R6)
    for (int dc = 0; dc < 2; dc++)
      for (int j = 0; j < 6; j++) begin
        logic [15:0] s;
        logic [7:0] a;
        s = dc ? 16'h0080 : 16'h0040;
        a = (j < 5) ? patt(dc ? s - j : s + j, 8'h21) : patt(s + 120, 8'h21);
        run(2'd1, dc[0], 1'b1, s, 16'h0000, 16'd5, a, 8'h29 + 8'(j), 1'b0, 8'h21);
      end

    // pointer wrap across the address space top (R3)
    run(2'd0, 1'b0, 1'b1, 16'hFFFE, 16'h7FFE, 16'd4, 8'h00, 8'h81, 1'b0, 8'h44);
    run(2'd2, 1'b1, 1'b1, 16'h0001, 16'h0000, 16'h0377, 8'h00, 8'hFF, 1'b0, 8'h13);

    // start held and inputs changing while busy (R2)
    run(2'd0, 1'b0, 1'b1, 16'h0010, 16'h00A0, 16'd3, 8'h00, 8'h00, 1'b1, 8'h07);
    run(2'd1, 1'b1, 1'b1, 16'h0070, 16'h0000, 16'd6, patt(16'h006D, 8'h09), 8'h3C, 1'b1, 8'h09);
    run(2'd3, 1'b0, 1'b1, 16'h0030, 16'h0000, 16'h0452, 8'h00, 8'h02, 1'b1, 8'h55);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R12 watchdog: actual still running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule